// File: doc/BRIEF.md
# Peripheral Reset and Clock-Gate Register Bank

This block is the register bank of a clock-and-reset controller. A host reaches it over a word-addressed read/write bus. It drives two arrays of output lines: one per-peripheral reset line and one per-peripheral clock-enable line. Two contiguous runs of 32-bit registers are tied to these lines. Every other register in range is plain storage.

The reset run only releases resets. When a stored bit goes from 1 to 0 on a write, its reset line drops to 0. The enable run only switches clocks on. When a stored bit goes from 0 to 1 on a write, its enable line rises to 1. Transitions in the other direction update the stored word but leave the lines alone. A line's index is the register's word offset inside its run times 32, plus the bit position. Lines are registered and follow the write by one clock.

Top module: `periph_gate_regs`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, all reset lines are 1 and all enable lines are 0.
- R2: `addr` is a word address. A read returns the selected word on `rdata` one cycle after `rd_en` is sampled high, and `rdata` holds its value in cycles without `rd_en`. A read and a write to the same word in the same cycle return the word as it was before the write.
- R3: For an address above the last valid word (default 15), a read returns 0 and a write is discarded: no register or line changes.
- R4: With the default layout, words 4 to 7 form the reset run. A write that turns a stored bit b of word w from 1 to 0 drives `rst_lines[(w-4)*32+b]` to 0.
- R5: In the reset run, a stored bit that goes from 0 to 1, or that stays the same, leaves its reset line unchanged.
- R6: With the default layout, words 8 to 11 form the enable run. A write that turns a stored bit b of word w from 0 to 1 drives `ena_lines[(w-8)*32+b]` to 1.
- R7: In the enable run, a stored bit that goes from 1 to 0, or that stays the same, leaves its enable line unchanged.
- R8: Any in-range write stores the full written word, whatever edges it caused.
- R9: Words outside both runs (default 0 to 3 and 12 to 15) store and return data verbatim and never move a line.
- R10: Lines change only in the cycle after an accepted write to their own run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (6) | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| rst_lines | output | RST_NUM*32 (128) | Per-peripheral reset lines, 1 = held in reset |
| ena_lines | output | ENA_NUM*32 (128) | Per-peripheral clock enables, 1 = enabled |

## Verification
A wrong stored word shows up in two ways: as a wrong `rdata` on the next read, and one write later as a missing or extra line change, because the edge rules compare against that stored word. A line that moves on the wrong edge, on a write to another run, or without a write is seen at the ports on the clock after the offending write. The bench compares both line arrays after every write and every idle cycle, so such a fault appears within one cycle. It also reads back data so that storage faults surface before later writes hide them.

// File: rtl/pgr_pkg.sv
// Package: shared constants and the edge-rule selector for the register bank.
// Assumes 32-bit registers; every run of lines uses one line per register bit.
package pgr_pkg;
    localparam int WORD_W = 32;

    // Which bit transition of a run moves its lines.
    typedef enum logic {
        EDGE_FALL_CLEARS = 1'b0,   // 1->0 in storage drives the line to 0
        EDGE_RISE_SETS   = 1'b1    // 0->1 in storage drives the line to 1
    } edge_rule_e;
endpackage

// File: rtl/pgr_store.sv
// Module: pgr_store
// The word storage of the bank, with range checking, a registered read port
// and all words exposed as one flat vector for the line-control units.
// Assumes ADDR_W is wide enough to hold NREG-1 and NREG >= 2.
module pgr_store #(
    parameter int ADDR_W = 6,
    parameter int NREG   = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [pgr_pkg::WORD_W-1:0]        wdata,
    output logic [pgr_pkg::WORD_W-1:0]        rdata,
    output logic [NREG*pgr_pkg::WORD_W-1:0]   words_flat
);
    localparam int W     = pgr_pkg::WORD_W;
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic [W-1:0]     words [NREG];
    logic             in_rng;
    logic [IDX_W-1:0] idx;

    assign in_rng = (32'(addr) < 32'(NREG));
    assign idx    = addr[IDX_W-1:0];

    // Purpose: clear all words on reset, store full in-range writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en && in_rng) begin
            words[idx] <= wdata;
        end
    end

    // Purpose: registered read, zero when out of range, held without rd_en.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= in_rng ? words[idx] : '0;
        end
    end

    // Purpose: expose every stored word to the line-control units.
    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign words_flat[g*W +: W] = words[g];
    end
endmodule

// File: rtl/pgr_line_group.sv
// Module: pgr_line_group
// Drives the output lines of one run of NUM registers starting at word BASE.
// On a write to a word in the run, it compares the new data with the word
// stored before the write and moves only the lines whose bit made the
// transition that RULE selects. Lines are registered (one cycle after the write).
// Assumes the caller passes the run's stored words, low word first.
module pgr_line_group #(
    parameter int                  ADDR_W = 6,
    parameter int                  BASE   = 4,
    parameter int                  NUM    = 4,
    parameter pgr_pkg::edge_rule_e RULE   = pgr_pkg::EDGE_FALL_CLEARS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [pgr_pkg::WORD_W-1:0]       wdata,
    input  logic [NUM*pgr_pkg::WORD_W-1:0]   run_words,
    output logic [NUM*pgr_pkg::WORD_W-1:0]   lines
);
    localparam int           W         = pgr_pkg::WORD_W;
    localparam logic [W-1:0] IDLE_WORD = (RULE == pgr_pkg::EDGE_FALL_CLEARS) ? '1 : '0;

    for (genvar k = 0; k < NUM; k++) begin : g_slot
        localparam int SLOT = BASE + k;

        logic         hit;
        logic [W-1:0] prev;
        logic [W-1:0] moved;
        logic [W-1:0] slot_q;

        assign hit  = wr_en && (32'(addr) == 32'(SLOT));
        assign prev = run_words[k*W +: W];

        // Purpose: pick the bits whose transition this run reacts to.
        if (RULE == pgr_pkg::EDGE_FALL_CLEARS) begin : g_fall
            assign moved = prev & ~wdata;
        end else begin : g_rise
            assign moved = ~prev & wdata;
        end

        // Purpose: hold the lines of this word, update them on a qualifying write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= IDLE_WORD;
            end else if (hit) begin
                if (RULE == pgr_pkg::EDGE_FALL_CLEARS) begin
                    slot_q <= slot_q & ~moved;
                end else begin
                    slot_q <= slot_q | moved;
                end
            end
        end

        assign lines[k*W +: W] = slot_q;
    end
endmodule

// File: rtl/periph_gate_regs.sv
// Module: periph_gate_regs (top)
// Register bank of a clock-and-reset controller: plain storage plus a run of
// reset-release words and a run of clock-enable words that drive line arrays.
// Assumes the two runs do not overlap and both lie at or below LAST_IDX.
module periph_gate_regs #(
    parameter int ADDR_W   = 6,
    parameter int RST_BASE = 4,
    parameter int RST_NUM  = 4,
    parameter int ENA_BASE = 8,
    parameter int ENA_NUM  = 4,
    parameter int LAST_IDX = 15
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic                               rd_en,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [pgr_pkg::WORD_W-1:0]         wdata,
    output logic [pgr_pkg::WORD_W-1:0]         rdata,
    output logic [RST_NUM*pgr_pkg::WORD_W-1:0] rst_lines,
    output logic [ENA_NUM*pgr_pkg::WORD_W-1:0] ena_lines
);
    localparam int W    = pgr_pkg::WORD_W;
    localparam int NREG = LAST_IDX + 1;

    logic [NREG*W-1:0] words_flat;

    // Storage and read port.
    pgr_store #(
        .ADDR_W (ADDR_W),
        .NREG   (NREG)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .words_flat (words_flat)
    );

    // Reset run: only releases (1->0) reach the lines.
    pgr_line_group #(
        .ADDR_W (ADDR_W),
        .BASE   (RST_BASE),
        .NUM    (RST_NUM),
        .RULE   (pgr_pkg::EDGE_FALL_CLEARS)
    ) u_rst_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .run_words (words_flat[RST_BASE*W +: RST_NUM*W]),
        .lines     (rst_lines)
    );

    // Enable run: only switch-ons (0->1) reach the lines.
    pgr_line_group #(
        .ADDR_W (ADDR_W),
        .BASE   (ENA_BASE),
        .NUM    (ENA_NUM),
        .RULE   (pgr_pkg::EDGE_RISE_SETS)
    ) u_ena_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .run_words (words_flat[ENA_BASE*W +: ENA_NUM*W]),
        .lines     (ena_lines)
    );
endmodule

// File: rtl/pgr_checker.sv
// Module: pgr_checker
// Port-level properties of periph_gate_regs, attached with bind below.
module pgr_checker #(
    parameter int ADDR_W   = 6,
    parameter int RST_BASE = 4,
    parameter int RST_NUM  = 4,
    parameter int ENA_BASE = 8,
    parameter int ENA_NUM  = 4,
    parameter int LAST_IDX = 15
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic                          rd_en,
    input logic [ADDR_W-1:0]             addr,
    input logic [31:0]                   rdata,
    input logic [RST_NUM*32-1:0]         rst_lines,
    input logic [ENA_NUM*32-1:0]         ena_lines
);
    AST_RST_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_lines & ~$past(rst_lines)) == '0);                                  // R5

    AST_ENA_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (~ena_lines & $past(ena_lines)) == '0);                                  // R7

    AST_RST_FALL_FROM_OWN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((~rst_lines & $past(rst_lines)) != '0) |->
        ($past(wr_en) && 32'($past(addr)) >= 32'(RST_BASE)
                      && 32'($past(addr)) <  32'(RST_BASE + RST_NUM)));          // R10

    AST_ENA_RISE_FROM_OWN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ena_lines & ~$past(ena_lines)) != '0) |->
        ($past(wr_en) && 32'($past(addr)) >= 32'(ENA_BASE)
                      && 32'($past(addr)) <  32'(ENA_BASE + ENA_NUM)));          // R10

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && 32'($past(addr)) > 32'(LAST_IDX)) |-> (rdata == '0));   // R3

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata));                                       // R2
endmodule

bind periph_gate_regs pgr_checker #(
    .ADDR_W   (ADDR_W),
    .RST_BASE (RST_BASE),
    .RST_NUM  (RST_NUM),
    .ENA_BASE (ENA_BASE),
    .ENA_NUM  (ENA_NUM),
    .LAST_IDX (LAST_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .rst_lines (rst_lines),
    .ena_lines (ena_lines)
);

// File: tb/sim_periph_gate_regs.sv
`timescale 1ns/1ps
// Bench for periph_gate_regs: directed corners plus seeded random traffic,
// checked against a bench-side model of storage and both line arrays.
module sim_periph_gate_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [5:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [127:0] rst_lines;
    logic [127:0] ena_lines;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0]  m_word [16];
    logic [127:0] m_rst;
    logic [127:0] m_ena;

    always #4 clk = ~clk;

    periph_gate_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_lines(rst_lines), .ena_lines(ena_lines)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of one write: R3 range, R4..R7 edge rules, R8 full store.
    task automatic model_write(input logic [5:0] a, input logic [31:0] d);
        if (a > 6'd15) return;
        for (int b = 0; b < 32; b++) begin
            if (a >= 6'd4 && a <= 6'd7 && m_word[a][b] && !d[b])
                m_rst[(int'(a) - 4) * 32 + b] = 1'b0;
            if (a >= 6'd8 && a <= 6'd11 && !m_word[a][b] && d[b])
                m_ena[(int'(a) - 8) * 32 + b] = 1'b1;
        end
        m_word[a] = d;
    endtask

    function automatic logic [31:0] model_read(input logic [5:0] a);
        return (a > 6'd15) ? 32'h0 : m_word[a];
    endfunction

    task automatic check_lines(input string req);
        check({req, " rst_lines"}, rst_lines, m_rst);
        check({req, " ena_lines"}, ena_lines, m_ena);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
        check_lines(req);
    endtask

    task automatic do_read(input logic [5:0] a, input string req);
        logic [31:0] exp;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp = model_read(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(req, {96'h0, rdata}, {96'h0, exp});
    endtask

    initial begin
        logic [31:0] held;
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) m_word[i] = '0;
        m_rst = '1;
        m_ena = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check_lines("R1");
        do_read(6'd0, "R1");
        do_read(6'd5, "R1");
        do_read(6'd9, "R1");

        // R5: 0->1 in reset run does not touch lines
        do_write(6'd5, 32'hFFFF_FFFF, "R5");
        // R4: release all but bits 4..7 of word 5
        do_write(6'd5, 32'h0000_00F0, "R4");
        check("R4 line 32", {127'h0, rst_lines[32]}, 128'h0);
        do_read(6'd5, "R8");
        do_write(6'd5, 32'h0, "R4");
        // R5: re-setting bits leaves released lines at 0
        do_write(6'd5, 32'hFFFF_FFFF, "R5");
        check("R5 line 36", {127'h0, rst_lines[36]}, 128'h0);

        // R6 / R7 on word 9
        do_write(6'd9, 32'h0000_0001, "R6");
        check("R6 line 32", {127'h0, ena_lines[32]}, 128'h1);
        do_write(6'd9, 32'h0, "R7");
        check("R7 line 32", {127'h0, ena_lines[32]}, 128'h1);
        do_read(6'd9, "R8");
        do_write(6'd11, 32'h8000_0000, "R6");
        check("R6 line 127", {127'h0, ena_lines[127]}, 128'h1);

        // R9: plain words
        do_write(6'd2, 32'hDEAD_BEEF, "R9");
        do_read(6'd2, "R9");
        do_write(6'd15, 32'h1234_5678, "R9");
        do_read(6'd15, "R9");

        // R3: out-of-range access
        do_write(6'd20, 32'hFFFF_FFFF, "R3");
        do_read(6'd20, "R3");
        do_write(6'd63, 32'h0, "R3");
        do_read(6'd63, "R3");

        // R2: read and write of the same word in one cycle returns the old word
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 6'd2; wdata = 32'h0BAD_F00D;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R2 read-before-write", {96'h0, rdata}, {96'h0, 32'hDEAD_BEEF});
        model_write(6'd2, 32'h0BAD_F00D);
        do_read(6'd2, "R2");
        // R2: rdata holds without rd_en
        held = rdata;
        do_write(6'd2, 32'h5555_AAAA, "R2");
        check("R2 hold", {96'h0, rdata}, {96'h0, held});

        // R10: idle cycles move nothing
        repeat (3) begin
            @(negedge clk);
            check_lines("R10");
        end

        // Seeded random traffic
        for (int n = 0; n < 400; n++) begin
            logic [5:0]  a;
            logic [31:0] d;
            a = 6'($urandom_range(0, 19));
            d = $urandom();
            if (($urandom() & 3) == 0) d = d & $urandom();
            case ($urandom_range(0, 2))
                0, 1:    do_write(a, d, "R10");
                default: do_read(a, "R8");
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule